// File: doc/BRIEF.md
# Pixel fetch address sequencer

This block is the per-dot timing core of a tile-based video renderer. It steps through every dot of a 341-dot scanline and every line of a frame. For each dot it reports which memory fetch the renderer makes and the level of address bit 12, the line that selects between the lower and upper pattern tables. It does not model the fetched data. It reproduces the address schedule, including the dummy fetches, the preroll of the next line's first tiles and the idle dots at the end of the line. Logic outside the block that watches bit 12, such as a scanline counter with a low-pass filter on rising edges, therefore sees the same edge timing it would see on real hardware.

Two control bits choose the table for background fetches and the table for sprite fetches. A rendering-enable input stops all fetching. The dot and line counters keep running while rendering is off. The last line of the frame is the pre-render line. It is flagged on its own output and fetches exactly like a visible line.

Top module: `fetch_seq_top`

## Requirements
- R1: After a synchronous reset, `dot` is 0, `line` is 0 and `preRender` is 0.
- R2: `dot` increases by one each clock from 0 to 340, then returns to 0 while `line` increases by one.
- R3: `line` counts from 0 to 261 and wraps to 0 after line 261. `preRender` is 1 exactly when `line` is 261.
- R4: On a fetching line with rendering on, `region` gives the part of the line by dot. The encodings are 1 = background for dots 0–247, 2 = dummy background for dots 248–255, 3 = sprite for dots 256–319, 4 = preroll for dots 320–335 and 0 = idle for dots 336–340.
- R5: In the non-idle regions each group of 8 dots, aligned to a multiple of 8, fetches in a fixed order with two dots per fetch. `fetchKind` is 1 (name) on dots 0–1 of the group, 2 (attribute) on dots 2–3, 3 (pattern low) on dots 4–5 and 4 (pattern high) on dots 6–7. It is 0 when no fetch takes place.
- R6: `a12` is 0 on every dot whose `fetchKind` is name, attribute or none.
- R7: On pattern dots `a12` equals `sprHiSel` in the sprite region and `bgHiSel` in the background, dummy and preroll regions.
- R8: With only `sprHiSel` set, the first rise of `a12` in a line is at dot 260, and the line has 8 rises in all. With only `bgHiSel` set, `a12` rises at dot 4 and has its first rise of the preroll region at dot 324.
- R9: While `renderEn` is 0, `region` and `fetchKind` are 0 and `a12` is 0. The counters keep advancing.
- R10: Lines 240 to 260 fetch nothing: `region` = 0, `fetchKind` = 0 and `a12` = 0.
- R11: The pre-render line (261) follows the same fetch and `a12` schedule as a visible line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| renderEn | input | 1 | Enables fetching when 1 |
| bgHiSel | input | 1 | Background uses the upper pattern table when 1 |
| sprHiSel | input | 1 | Sprites use the upper pattern table when 1 |
| dot | output | 9 | Dot within the line, 0–340 |
| line | output | 9 | Line within the frame, 0–261 |
| preRender | output | 1 | High on the pre-render line |
| region | output | 3 | Part of the line (encoding in R4) |
| fetchKind | output | 3 | Current fetch (encoding in R5) |
| a12 | output | 1 | Level of pattern address bit 12 |

## Verification
The schedule is sampled at chosen dots under four table-select patterns: background upper only, sprite upper only, both and neither. Each pattern is tried in every region. This separates which select bit drives a pattern fetch in each region, and it shows that name and attribute dots stay low whatever the selects are. Line-wide scans count the rises of `a12` and find the first one for each select pattern. The scans show the dot-260, dot-4 and dot-324 edges, and with them any off-by-one in the group order. Further samples on blanking lines, on the pre-render line and with rendering disabled separate lines that fetch from lines that do not, and check the counters at their wrap points and after a mid-frame reset.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  typedef enum logic [2:0] {
    REG_IDLE  = 3'd0,
    REG_BG    = 3'd1,
    REG_DUMMY = 3'd2,
    REG_SPR   = 3'd3,
    REG_PRE   = 3'd4
  } region_e;

  typedef enum logic [2:0] {
    FK_NONE  = 3'd0,
    FK_NAME  = 3'd1,
    FK_ATTR  = 3'd2,
    FK_PATLO = 3'd3,
    FK_PATHI = 3'd4
  } fetch_e;

  // Strobes from control to datapath for the current dot
  typedef struct packed {
    logic    active;
    region_e region;
    logic [2:0] slot;
  } strobe_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import fetch_seq_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VIS_LINES = 240,
  parameter int BG_END    = 248,
  parameter int DUMMY_END = 256,
  parameter int SPR_END   = 320,
  parameter int PRE_END   = 336
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       renderEn,
  output logic [$clog2(DOTS)-1:0]    dot,
  output logic [$clog2(LINES)-1:0]   line,
  output logic                       preRender,
  output strobe_t                    strb
);

  localparam int DW = $clog2(DOTS);
  localparam int LW = $clog2(LINES);
  localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS - 1);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);
  localparam logic [LW-1:0] VIS_LIM   = LW'(VIS_LINES);
  localparam logic [DW-1:0] BG_LIM    = DW'(BG_END);
  localparam logic [DW-1:0] DUMMY_LIM = DW'(DUMMY_END);
  localparam logic [DW-1:0] SPR_LIM   = DW'(SPR_END);
  localparam logic [DW-1:0] PRE_LIM   = DW'(PRE_END);

  region_e rawRegion;
  logic    fetchLine;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
    end else if (dot == LAST_DOT) begin
      dot  <= '0;
      line <= (line == LAST_LINE) ? '0 : line + 1'b1;
    end else begin
      dot  <= dot + 1'b1;
    end
  end

  always_comb begin
    if (dot < BG_LIM)         rawRegion = REG_BG;
    else if (dot < DUMMY_LIM) rawRegion = REG_DUMMY;
    else if (dot < SPR_LIM)   rawRegion = REG_SPR;
    else if (dot < PRE_LIM)   rawRegion = REG_PRE;
    else                      rawRegion = REG_IDLE;
  end

  assign preRender = (line == LAST_LINE);
  assign fetchLine = (line < VIS_LIM) || preRender;

  always_comb begin
    strb.active = renderEn && fetchLine && (rawRegion != REG_IDLE);
    strb.region = strb.active ? rawRegion : REG_IDLE;
    strb.slot   = dot[2:0];
  end

  // R2
  dot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot != LAST_DOT) |=> (dot == DW'($past(dot) + 1'b1)));

  // R2
  dot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == LAST_DOT && line != LAST_LINE) |=> (dot == '0 && line == LW'($past(line) + 1'b1)));

  // R3
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == LAST_DOT && line == LAST_LINE) |=> (line == '0 && !preRender));

  // R10
  no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line >= VIS_LIM && !preRender) |-> !strb.active);

  // R4
  idle_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot >= PRE_LIM) |-> !strb.active);

endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  input  logic    bgHiSel,
  input  logic    sprHiSel,
  output region_e region,
  output fetch_e  fetchKind,
  output logic    a12
);

  logic tableSel;
  logic patDot;

  always_comb begin
    if (!strb.active) begin
      fetchKind = FK_NONE;
    end else begin
      unique case (strb.slot[2:1])
        2'd0:    fetchKind = FK_NAME;
        2'd1:    fetchKind = FK_ATTR;
        2'd2:    fetchKind = FK_PATLO;
        default: fetchKind = FK_PATHI;
      endcase
    end
  end

  assign region   = strb.region;
  assign tableSel = (strb.region == REG_SPR) ? sprHiSel : bgHiSel;
  assign patDot   = strb.active && strb.slot[2];
  assign a12      = patDot && tableSel;

  // R6
  a12_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a12 |-> (fetchKind == FK_PATLO || fetchKind == FK_PATHI));

  // R5
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchKind == FK_NAME && strb.slot[0]) |=> (fetchKind == FK_ATTR || fetchKind == FK_NONE));

endmodule

// File: rtl/fetch_seq_top.sv
module fetch_seq_top
  import fetch_seq_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VIS_LINES = 240,
  parameter int BG_END    = 248,
  parameter int DUMMY_END = 256,
  parameter int SPR_END   = 320,
  parameter int PRE_END   = 336
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     renderEn,
  input  logic                     bgHiSel,
  input  logic                     sprHiSel,
  output logic [$clog2(DOTS)-1:0]  dot,
  output logic [$clog2(LINES)-1:0] line,
  output logic                     preRender,
  output logic [2:0]               region,
  output logic [2:0]               fetchKind,
  output logic                     a12
);

  strobe_t strb;
  region_e regionE;
  fetch_e  kindE;

  fetch_seq_ctrl #(
    .DOTS(DOTS), .LINES(LINES), .VIS_LINES(VIS_LINES), .BG_END(BG_END),
    .DUMMY_END(DUMMY_END), .SPR_END(SPR_END), .PRE_END(PRE_END)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .renderEn(renderEn),
    .dot(dot), .line(line), .preRender(preRender), .strb(strb)
  );

  fetch_seq_dp uDp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .bgHiSel(bgHiSel), .sprHiSel(sprHiSel),
    .region(regionE), .fetchKind(kindE), .a12(a12)
  );

  assign region    = regionE;
  assign fetchKind = kindE;

  // R9
  render_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !renderEn |-> (!a12 && fetchKind == 3'd0 && region == 3'd0));

endmodule

// File: tb/sim_fetch_seq_top.sv
module sim_fetch_seq_top;

  localparam int DOTS  = 341;
  localparam int LINES = 262;
  localparam int FRAME = DOTS * LINES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic renderEn = 1'b0, bgHiSel = 1'b0, sprHiSel = 1'b0;
  logic [8:0] dot, line;
  logic preRender, a12;
  logic [2:0] region, fetchKind;

  int errors = 0;
  int checks = 0;
  int pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fetch_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .renderEn(renderEn), .bgHiSel(bgHiSel),
    .sprHiSel(sprHiSel), .dot(dot), .line(line), .preRender(preRender),
    .region(region), .fetchKind(fetchKind), .a12(a12)
  );

  typedef struct packed {
    int   ln;
    int   dt;
    logic bg;
    logic spr;
    logic ren;
    logic [2:0] expReg;
    logic [2:0] expKind;
    logic expA12;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{0,   0,   1'b1, 1'b0, 1'b1, 3'd1, 3'd1, 1'b0}, // R4 R5 R6
    '{0,   3,   1'b1, 1'b1, 1'b1, 3'd1, 3'd2, 1'b0}, // R5 R6
    '{0,   4,   1'b1, 1'b0, 1'b1, 3'd1, 3'd3, 1'b1}, // R7
    '{0,   4,   1'b0, 1'b1, 1'b1, 3'd1, 3'd3, 1'b0}, // R7
    '{0,   7,   1'b1, 1'b0, 1'b1, 3'd1, 3'd4, 1'b1}, // R5
    '{0,   250, 1'b1, 1'b1, 1'b1, 3'd2, 3'd2, 1'b0}, // R4 R6
    '{0,   252, 1'b1, 1'b0, 1'b1, 3'd2, 3'd3, 1'b1}, // R7
    '{0,   256, 1'b1, 1'b1, 1'b1, 3'd3, 3'd1, 1'b0}, // R4 R6
    '{0,   260, 1'b0, 1'b1, 1'b1, 3'd3, 3'd3, 1'b1}, // R7
    '{0,   260, 1'b1, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0}, // R7
    '{0,   262, 1'b0, 1'b1, 1'b1, 3'd3, 3'd4, 1'b1}, // R5
    '{0,   324, 1'b1, 1'b0, 1'b1, 3'd4, 3'd3, 1'b1}, // R4 R7
    '{0,   324, 1'b0, 1'b1, 1'b1, 3'd4, 3'd3, 1'b0}, // R7
    '{0,   335, 1'b1, 1'b0, 1'b1, 3'd4, 3'd4, 1'b1}, // R4
    '{0,   336, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0}, // R4
    '{0,   340, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0}, // R4
    '{1,   0,   1'b0, 1'b0, 1'b1, 3'd1, 3'd1, 1'b0}, // R2
    '{5,   4,   1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0}, // R9
    '{5,   260, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0}, // R9
    '{239, 100, 1'b1, 1'b0, 1'b1, 3'd1, 3'd3, 1'b1}, // R5 R7
    '{240, 4,   1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0}, // R10
    '{260, 260, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0}, // R10
    '{261, 4,   1'b1, 1'b0, 1'b1, 3'd1, 3'd3, 1'b1}, // R11
    '{261, 260, 1'b0, 1'b1, 1'b1, 3'd3, 3'd3, 1'b1}  // R11
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (line %0d dot %0d)", tag, act, exp, line, dot);
    end
  endtask

  task automatic step(input int n);
    if (n > 0) begin
      repeat (n) @(posedge clk);
      @(negedge clk);
    end
    pos = (pos + n) % FRAME;
  endtask

  task automatic goto(input int ln, input int dt);
    int tgt;
    tgt = ln * DOTS + dt;
    step((tgt - pos + FRAME) % FRAME);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int first;
    int rises;
    logic prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 dot", dot, 0);
    chk("R1 line", line, 0);
    chk("R1 preRender", preRender, 0);
    rst_n = 1'b1;
    pos = 0;
    #1;

    for (int i = 0; i < NV; i++) begin
      goto(VEC[i].ln, VEC[i].dt);
      renderEn = VEC[i].ren;
      bgHiSel  = VEC[i].bg;
      sprHiSel = VEC[i].spr;
      #1;
      chk("R2 dot", dot, VEC[i].dt);
      chk("R3 line", line, VEC[i].ln);
      chk("R4 region", region, VEC[i].expReg);
      chk("R5 fetchKind", fetchKind, VEC[i].expKind);
      chk("R7 a12", a12, VEC[i].expA12);
    end

    // R3 pre-render flag and wrap
    renderEn = 1'b1;
    goto(260, 340);
    chk("R3 preRender on 260", preRender, 0);
    goto(261, 0);
    chk("R3 preRender on 261", preRender, 1);
    goto(261, 340);
    chk("R3 preRender end 261", preRender, 1);
    step(1);
    chk("R3 wrap line", line, 0);
    chk("R2 wrap dot", dot, 0);
    chk("R3 preRender after wrap", preRender, 0);

    // R8 sprite-upper only: first rise and rise count on line 0
    bgHiSel = 1'b0; sprHiSel = 1'b1;
    #1;
    first = -1; rises = 0; prev = 1'b0;
    for (int d = 0; d < DOTS; d++) begin
      if (a12 && !prev) begin
        rises++;
        if (first < 0) first = d;
      end
      // R6 name/attribute dots never high
      if ((fetchKind == 3'd1 || fetchKind == 3'd2) && a12) chk("R6 a12 on name/attr", a12, 0);
      prev = a12;
      step(1);
    end
    chk("R8 sprite first rise", first, 260);
    chk("R8 sprite rise count", rises, 8);

    // R8 background-upper only: rise at dot 4 and first preroll rise at 324
    bgHiSel = 1'b1; sprHiSel = 1'b0;
    goto(1, 3);
    chk("R8 bg low before 4", a12, 0);
    step(1);
    chk("R8 bg rise at 4", a12, 1);
    goto(1, 319);
    first = -1; prev = a12;
    for (int d = 320; d < DOTS; d++) begin
      step(1);
      if (a12 && !prev && first < 0) first = d;
      prev = a12;
    end
    chk("R8 bg preroll rise", first, 324);

    // R9 counters keep running while disabled
    renderEn = 1'b0;
    goto(3, 10);
    step(5);
    chk("R9 dot runs", dot, 15);
    chk("R9 kind idle", fetchKind, 0);

    // R1 reset mid-frame
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 dot after reset", dot, 0);
    chk("R1 line after reset", line, 0);
    finish_run();
  end

endmodule